// File: doc/BRIEF.md
# Link configuration shadow register file

This block keeps a local copy of the link configuration that a display source programs into its sink. Writes seen on the sideband channel arrive as an address, a byte and a strobe, and the block captures those aimed at the registers it mirrors. A local register bus can reach the same copy indirectly. Three bytes on that bus form a 20-bit target address, and a fourth byte is the data window into the copy. The same bus also holds the control bits and a table of equalizer gain codes.

Stored values are kept in a compact internal form, and reads return that form, not the byte that was written. The block checks every lane count and every swing/pre-emphasis pair. When any value is forbidden it raises an error flag and gates off every lane. From the stored state it drives a per-lane enable mask, per-lane swing and pre-emphasis levels, and a per-lane 3-bit equalizer code. The code is picked from the table by the lane's trained pre-emphasis level.

Top module: `link_cfg_shadow`

## Requirements
- R1: The bandwidth register (shadow address 00100h) stores write 06h as read code 00h, write 0Ah as 01h and write 14h as 02h. Any other byte stores 02h. `link_rate` shows the stored code, and the code 3 never appears.
- R2: The lane-count register (00101h) stores writes 00h, 01h, 02h and 04h as read values 00h, 01h, 03h and 0Fh. That value is the lane mask driven on `lane_en`. Any other byte reads 00h and disables every lane.
- R3: The lane training registers (00103h + lane) take the swing from write bits 1:0 and the pre-emphasis from write bits 4:3. Bits 7:5 and bit 2 are ignored. A read returns pre-emphasis in bits 3:2 and swing in bits 1:0. `drv_swing`/`drv_pre` carry 2 bits per lane, with lane 0 in the low bits.
- R4: A swing/pre-emphasis pair whose two levels sum to more than 3 is forbidden (01/11, 10/10, 10/11, 11/01, 11/10, 11/11). While any lane holds such a pair, `lane_en` is 0. The mask returns once every pair is valid again.
- R5: Post-cursor register 0010Fh takes lane 0 from write bits 1:0 and lane 1 from write bits 5:4. Register 00110h does the same for lanes 2 and 3. A read returns the lower lane in bits 1:0 and the upper lane in bits 3:2.
- R6: The local bus has these registers: address 0 holds target bits 19:16 (in bits 3:0), address 1 holds bits 15:8, address 2 holds bits 7:0, and address 3 reads and writes the shadow register at that target. Unmapped targets and local addresses read 00h and ignore writes.
- R7: Writing 1 to control bit 5 (local address 4) clears all four lane training registers in the next cycle. The bit is write-only and reads 0. A snooped write to a training register in the same cycle wins over the clear.
- R8: Control bit 7 enables equalizer codes from the table, and control bit 6 enables training-based selection. With both set, each lane uses the table field indexed by its pre-emphasis level. With bit 6 clear, each lane uses its level-1 field. With bit 7 clear, each code is 0.
- R9: The table entry for lane L sits at local address 8+2L, with the level-0 field in bits 6:4 and the level-1 field in bits 2:0. Address 9+2L holds level 2 in bits 6:4 and level 3 in bits 2:0. Bits 7 and 3 read 0.
- R10: When a snooped write and a local data-window write target the same shadow register in one cycle, the snooped byte is stored. Writes to different registers in one cycle both take effect.
- R11: After reset, bandwidth reads 01h, the lane count reads 00h, and training, post-cursor, table and address bytes are 0. Control reads 40h.
- R12: `cfg_err` is 1 exactly when the lane count is forbidden or any lane holds a forbidden pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snoop_we | input | 1 | Snooped sideband write strobe |
| snoop_addr | input | 20 | Snooped write address |
| snoop_wdata | input | 8 | Snooped write byte |
| lb_we | input | 1 | Local bus write strobe |
| lb_addr | input | 4 | Local bus register address |
| lb_wdata | input | 8 | Local bus write byte |
| lb_rdata | output | 8 | Local bus read byte (combinational) |
| link_rate | output | 2 | Stored bandwidth code |
| lane_en | output | 4 | Per-lane output enable mask |
| cfg_err | output | 1 | Forbidden configuration present |
| drv_swing | output | 8 | Per-lane swing level |
| drv_pre | output | 8 | Per-lane pre-emphasis level |
| eq_code | output | 12 | Per-lane 3-bit equalizer code |

## Verification
The hardest situations to reach are the collisions in one cycle. One is a snooped write and a data-window write to the same shadow register. Another is a snooped training write landing in the cycle of the clear strobe. Both need the three address bytes to be set up first, so that the data-window write can be timed against a snooped strobe. The bench does this with directed sequences. It then runs a long random phase with a small set of targets, so that collisions and forbidden pairs recur often. A behavioural model checks every cycle.

// File: rtl/lcs_pkg.sv
// Shared constants, types and helpers for the link configuration shadow.
// Assumes 20-bit shadow addresses and byte-wide data.
package lcs_pkg;

    // Shadow addresses that neighbours decode
    localparam logic [19:0] ADR_BW     = 20'h00100;
    localparam logic [19:0] ADR_LCNT   = 20'h00101;
    localparam logic [19:0] ADR_TRAIN0 = 20'h00103;
    localparam logic [19:0] ADR_PC2    = 20'h0010F;

    // Local bus map
    localparam int LB_A_HI   = 0;
    localparam int LB_A_MID  = 1;
    localparam int LB_A_LO   = 2;
    localparam int LB_A_DATA = 3;
    localparam int LB_A_CTRL = 4;
    localparam int LB_A_EQ   = 8;

    // Control register bit positions
    localparam int CTRL_EQ_EN  = 7;
    localparam int CTRL_TR_EN  = 6;
    localparam int CTRL_CLR    = 5;

    typedef struct packed {
        logic [1:0] pre;
        logic [1:0] swing;
    } lane_drv_t;

    // Write byte to stored bandwidth code
    function automatic logic [1:0] bw_encode(input logic [7:0] wd);
        case (wd)
            8'h06:   return 2'd0;
            8'h0A:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    // A pair is forbidden when its two levels add up to more than 3
    function automatic logic pair_bad(input lane_drv_t d);
        return ({1'b0, d.swing} + {1'b0, d.pre}) > 3'd3;
    endfunction

endpackage

// File: rtl/lcs_sink_regs.sv
// Shadow copy of the sink link configuration registers.
// Two write ports (snooped, local indirect); snooped wins on the same address.
// Assumes LANES is 4 or fewer so every training address stays below 0010Fh.
module lcs_sink_regs
    import lcs_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 20,
    parameter int DW    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  s_we,
    input  logic [AW-1:0]         s_addr,
    input  logic [DW-1:0]         s_wdata,
    input  logic                  l_we,
    input  logic [AW-1:0]         l_addr,
    input  logic [DW-1:0]         l_wdata,
    input  logic                  clr_train,
    input  logic [AW-1:0]         rd_addr,
    output logic [DW-1:0]         rd_data,
    output logic [1:0]            rate_code,
    output logic [LANES-1:0]      lane_mask,
    output logic                  lc_bad,
    output lane_drv_t [LANES-1:0] lane_drv
);

    localparam int PAIRS = LANES / 2;

    function automatic logic hit(input logic we, input logic [AW-1:0] a,
                                 input logic [AW-1:0] t);
        return we && (a == t);
    endfunction

    logic [1:0]            rate_q;
    logic [LANES-1:0]      mask_q;
    logic                  bad_q;
    lane_drv_t [LANES-1:0] drv_q;
    logic [LANES-1:0][1:0] pc_q;

    // Bandwidth register
    logic          bw_s, bw_l;
    logic [DW-1:0] bw_wd;
    assign bw_s  = hit(s_we, s_addr, AW'(ADR_BW));
    assign bw_l  = hit(l_we, l_addr, AW'(ADR_BW));
    assign bw_wd = bw_s ? s_wdata : l_wdata;

    // Store the translated bandwidth code
    always_ff @(posedge clk) begin
        if (!rst_n)            rate_q <= 2'd1;
        else if (bw_s || bw_l) rate_q <= bw_encode(bw_wd[7:0]);
    end

    // Lane count register
    logic             lc_s, lc_l;
    logic [DW-1:0]    lc_wd;
    logic             lc_ok;
    logic [LANES-1:0] lc_mask;
    assign lc_s  = hit(s_we, s_addr, AW'(ADR_LCNT));
    assign lc_l  = hit(l_we, l_addr, AW'(ADR_LCNT));
    assign lc_wd = lc_s ? s_wdata : l_wdata;

    // Decode a written lane count into a contiguous mask
    always_comb begin
        lc_ok   = (lc_wd == '0);
        lc_mask = '0;
        for (int n = 1; n <= LANES; n++) begin
            if (lc_wd == DW'(n) && ((n & (n - 1)) == 0)) begin
                lc_ok   = 1'b1;
                lc_mask = LANES'((1 << n) - 1);
            end
        end
    end

    // Store the lane mask and the forbidden-count flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            bad_q  <= 1'b0;
        end else if (lc_s || lc_l) begin
            mask_q <= lc_mask;
            bad_q  <= !lc_ok;
        end
    end

    // Per-lane training registers
    for (genvar i = 0; i < LANES; i++) begin : g_train
        localparam logic [AW-1:0] A = AW'(ADR_TRAIN0) + AW'(i);
        logic          sh, lh;
        logic [DW-1:0] wd;
        assign sh = hit(s_we, s_addr, A);
        assign lh = hit(l_we, l_addr, A);
        assign wd = sh ? s_wdata : l_wdata;

        // Capture swing and pre-emphasis; a write outranks the clear
        always_ff @(posedge clk) begin
            if (!rst_n)        drv_q[i] <= '0;
            else if (sh || lh) drv_q[i] <= {wd[4:3], wd[1:0]};
            else if (clr_train) drv_q[i] <= '0;
        end
    end

    // Post-cursor registers, two lanes per address
    for (genvar p = 0; p < PAIRS; p++) begin : g_pc2
        localparam logic [AW-1:0] A = AW'(ADR_PC2) + AW'(p);
        logic          sh, lh;
        logic [DW-1:0] wd;
        assign sh = hit(s_we, s_addr, A);
        assign lh = hit(l_we, l_addr, A);
        assign wd = sh ? s_wdata : l_wdata;

        // Capture both lanes' post-cursor levels
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_q[2*p]   <= '0;
                pc_q[2*p+1] <= '0;
            end else if (sh || lh) begin
                pc_q[2*p]   <= wd[1:0];
                pc_q[2*p+1] <= wd[5:4];
            end
        end
    end

    // Read mux in stored encoding
    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(ADR_BW))   rd_data = DW'(rate_q);
        if (rd_addr == AW'(ADR_LCNT)) rd_data = DW'(mask_q);
        for (int i = 0; i < LANES; i++) begin
            if (rd_addr == AW'(ADR_TRAIN0) + AW'(i))
                rd_data = DW'({drv_q[i].pre, drv_q[i].swing});
        end
        for (int p = 0; p < PAIRS; p++) begin
            if (rd_addr == AW'(ADR_PC2) + AW'(p))
                rd_data = DW'({pc_q[2*p+1], pc_q[2*p]});
        end
    end

    assign rate_code = rate_q;
    assign lane_mask = mask_q;
    assign lc_bad    = bad_q;
    assign lane_drv  = drv_q;

endmodule

// File: rtl/lcs_local_regs.sv
// Local bus registers: indirect address bytes, data window, control and
// equalizer table. Reads are combinational; writes take one clock.
// Assumes EQW is 3 so each table field fits a nibble.
module lcs_local_regs
    import lcs_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 20,
    parameter int DW    = 8,
    parameter int LB_AW = 4,
    parameter int EQW   = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            lb_we,
    input  logic [LB_AW-1:0]                lb_addr,
    input  logic [DW-1:0]                   lb_wdata,
    output logic [DW-1:0]                   lb_rdata,
    input  logic [DW-1:0]                   shadow_rd,
    output logic [AW-1:0]                   ind_addr,
    output logic                            ind_we,
    output logic                            clr_train,
    output logic                            eq_en,
    output logic                            train_en,
    output logic [LANES-1:0][3:0][EQW-1:0]  eq_tab
);

    localparam int HI_W = AW - 16;

    logic [HI_W-1:0] hi_q;
    logic [7:0]      mid_q, lo_q;
    logic            eq_en_q, tr_en_q;
    logic [LANES-1:0][3:0][EQW-1:0] tab_q;

    logic wr_hi, wr_mid, wr_lo, wr_ctrl;
    assign wr_hi   = lb_we && (lb_addr == LB_AW'(LB_A_HI));
    assign wr_mid  = lb_we && (lb_addr == LB_AW'(LB_A_MID));
    assign wr_lo   = lb_we && (lb_addr == LB_AW'(LB_A_LO));
    assign wr_ctrl = lb_we && (lb_addr == LB_AW'(LB_A_CTRL));

    // Indirect address bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            mid_q <= '0;
            lo_q  <= '0;
        end else begin
            if (wr_hi)  hi_q  <= lb_wdata[HI_W-1:0];
            if (wr_mid) mid_q <= lb_wdata[7:0];
            if (wr_lo)  lo_q  <= lb_wdata[7:0];
        end
    end

    // Control enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_en_q <= 1'b0;
            tr_en_q <= 1'b1;
        end else if (wr_ctrl) begin
            eq_en_q <= lb_wdata[CTRL_EQ_EN];
            tr_en_q <= lb_wdata[CTRL_TR_EN];
        end
    end

    // Equalizer table, two registers per lane
    for (genvar l = 0; l < LANES; l++) begin : g_tab
        localparam logic [LB_AW-1:0] A0 = LB_AW'(LB_A_EQ + 2*l);
        localparam logic [LB_AW-1:0] A1 = LB_AW'(LB_A_EQ + 2*l + 1);

        // Store the four level fields of one lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tab_q[l] <= '0;
            end else if (lb_we && lb_addr == A0) begin
                tab_q[l][0] <= lb_wdata[4 +: EQW];
                tab_q[l][1] <= lb_wdata[0 +: EQW];
            end else if (lb_we && lb_addr == A1) begin
                tab_q[l][2] <= lb_wdata[4 +: EQW];
                tab_q[l][3] <= lb_wdata[0 +: EQW];
            end
        end
    end

    // Read mux for the local map
    always_comb begin
        lb_rdata = '0;
        case (int'(lb_addr))
            LB_A_HI:   lb_rdata = DW'(hi_q);
            LB_A_MID:  lb_rdata = DW'(mid_q);
            LB_A_LO:   lb_rdata = DW'(lo_q);
            LB_A_DATA: lb_rdata = shadow_rd;
            LB_A_CTRL: lb_rdata = DW'({eq_en_q, tr_en_q, 6'b0});
            default: begin
                for (int l = 0; l < LANES; l++) begin
                    if (lb_addr == LB_AW'(LB_A_EQ + 2*l))
                        lb_rdata = DW'({1'b0, tab_q[l][0], 1'b0, tab_q[l][1]});
                    if (lb_addr == LB_AW'(LB_A_EQ + 2*l + 1))
                        lb_rdata = DW'({1'b0, tab_q[l][2], 1'b0, tab_q[l][3]});
                end
            end
        endcase
    end

    assign ind_addr  = {hi_q, mid_q, lo_q};
    assign ind_we    = lb_we && (lb_addr == LB_AW'(LB_A_DATA));
    assign clr_train = wr_ctrl && lb_wdata[CTRL_CLR];
    assign eq_en     = eq_en_q;
    assign train_en  = tr_en_q;
    assign eq_tab    = tab_q;

endmodule

// File: rtl/lcs_eq_select.sv
// Per-lane equalizer code selection from the programmable table.
// Pure combinational; assumes pre-emphasis levels are 2 bits.
module lcs_eq_select
    import lcs_pkg::*;
#(
    parameter int LANES = 4,
    parameter int EQW   = 3
) (
    input  logic                           eq_en,
    input  logic                           train_en,
    input  logic [LANES-1:0][3:0][EQW-1:0] eq_tab,
    input  lane_drv_t [LANES-1:0]          lane_drv,
    output logic [LANES-1:0][EQW-1:0]      eq_code
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Pick the trained-level field, the level-1 field, or zero
        always_comb begin
            if (!eq_en)        eq_code[l] = '0;
            else if (train_en) eq_code[l] = eq_tab[l][lane_drv[l].pre];
            else               eq_code[l] = eq_tab[l][1];
        end
    end

endmodule

// File: rtl/link_cfg_shadow.sv
// Top of the link configuration shadow: joins the local bus registers, the
// shadow copy and the equalizer selection, and forms the lane gating.
// Assumes a single clock and synchronous active-low reset.
module link_cfg_shadow
    import lcs_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 20,
    parameter int DW    = 8,
    parameter int LB_AW = 4,
    parameter int EQW   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   snoop_we,
    input  logic [AW-1:0]          snoop_addr,
    input  logic [DW-1:0]          snoop_wdata,
    input  logic                   lb_we,
    input  logic [LB_AW-1:0]       lb_addr,
    input  logic [DW-1:0]          lb_wdata,
    output logic [DW-1:0]          lb_rdata,
    output logic [1:0]             link_rate,
    output logic [LANES-1:0]       lane_en,
    output logic                   cfg_err,
    output logic [2*LANES-1:0]     drv_swing,
    output logic [2*LANES-1:0]     drv_pre,
    output logic [EQW*LANES-1:0]   eq_code
);

    logic [DW-1:0]                  shadow_rd;
    logic [AW-1:0]                  ind_addr;
    logic                           ind_we;
    logic                           clr_train;
    logic                           eq_en_w;
    logic                           train_en_w;
    logic [LANES-1:0][3:0][EQW-1:0] eq_tab;
    logic [LANES-1:0]               lane_mask;
    logic                           lc_bad;
    lane_drv_t [LANES-1:0]          lane_drv;
    logic [LANES-1:0][EQW-1:0]      eq_arr;
    logic [LANES-1:0]               pair_err;

    lcs_local_regs #(
        .LANES(LANES), .AW(AW), .DW(DW), .LB_AW(LB_AW), .EQW(EQW)
    ) u_local (
        .clk       (clk),
        .rst_n     (rst_n),
        .lb_we     (lb_we),
        .lb_addr   (lb_addr),
        .lb_wdata  (lb_wdata),
        .lb_rdata  (lb_rdata),
        .shadow_rd (shadow_rd),
        .ind_addr  (ind_addr),
        .ind_we    (ind_we),
        .clr_train (clr_train),
        .eq_en     (eq_en_w),
        .train_en  (train_en_w),
        .eq_tab    (eq_tab)
    );

    lcs_sink_regs #(
        .LANES(LANES), .AW(AW), .DW(DW)
    ) u_sink (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_we      (snoop_we),
        .s_addr    (snoop_addr),
        .s_wdata   (snoop_wdata),
        .l_we      (ind_we),
        .l_addr    (ind_addr),
        .l_wdata   (lb_wdata),
        .clr_train (clr_train),
        .rd_addr   (ind_addr),
        .rd_data   (shadow_rd),
        .rate_code (link_rate),
        .lane_mask (lane_mask),
        .lc_bad    (lc_bad),
        .lane_drv  (lane_drv)
    );

    lcs_eq_select #(
        .LANES(LANES), .EQW(EQW)
    ) u_eq (
        .eq_en    (eq_en_w),
        .train_en (train_en_w),
        .eq_tab   (eq_tab),
        .lane_drv (lane_drv),
        .eq_code  (eq_arr)
    );

    // Per-lane forbidden pair detection and output flattening
    for (genvar l = 0; l < LANES; l++) begin : g_out
        assign pair_err[l]          = pair_bad(lane_drv[l]);
        assign drv_swing[2*l +: 2]  = lane_drv[l].swing;
        assign drv_pre[2*l +: 2]    = lane_drv[l].pre;
        assign eq_code[EQW*l +: EQW] = eq_arr[l];
    end

    assign cfg_err = lc_bad || (|pair_err);
    assign lane_en = cfg_err ? '0 : lane_mask;

endmodule

// File: rtl/lcs_checker.sv
// Temporal checks on the shadow's ports and its equalizer enable.
module lcs_checker #(
    parameter int LANES = 4,
    parameter int AW    = 20,
    parameter int DW    = 8,
    parameter int LB_AW = 4,
    parameter int EQW   = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 snoop_we,
    input logic [AW-1:0]        snoop_addr,
    input logic [DW-1:0]        snoop_wdata,
    input logic                 lb_we,
    input logic [LB_AW-1:0]     lb_addr,
    input logic [DW-1:0]        lb_wdata,
    input logic [DW-1:0]        lb_rdata,
    input logic [1:0]           link_rate,
    input logic [LANES-1:0]     lane_en,
    input logic                 cfg_err,
    input logic [2*LANES-1:0]   drv_swing,
    input logic [2*LANES-1:0]   drv_pre,
    input logic [EQW*LANES-1:0] eq_code,
    input logic                 eq_en
);

    AST_RATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        link_rate != 2'd3); // R1

    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_en + LANES'(1)) & lane_en) == '0); // R2

    AST_ERR_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> lane_en == '0); // R4

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_addr == LB_AW'(4)) |-> !lb_rdata[5]); // R7

    AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_we && lb_addr == LB_AW'(4) && lb_wdata[5] && !snoop_we)
        |=> (drv_swing == '0 && drv_pre == '0)); // R7

    AST_EQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !eq_en |-> eq_code == '0); // R8

    AST_SNOOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_we && snoop_addr == AW'(20'h00100) && snoop_wdata == 8'h06
         && lb_we && lb_addr == LB_AW'(3)) |=> link_rate == 2'd0); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!snoop_we && !lb_we) |=> ($stable(lane_en) && $stable(eq_code)
                                  && $stable(link_rate))); // R12

endmodule

bind link_cfg_shadow lcs_checker #(
    .LANES(LANES), .AW(AW), .DW(DW), .LB_AW(LB_AW), .EQW(EQW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .snoop_we    (snoop_we),
    .snoop_addr  (snoop_addr),
    .snoop_wdata (snoop_wdata),
    .lb_we       (lb_we),
    .lb_addr     (lb_addr),
    .lb_wdata    (lb_wdata),
    .lb_rdata    (lb_rdata),
    .link_rate   (link_rate),
    .lane_en     (lane_en),
    .cfg_err     (cfg_err),
    .drv_swing   (drv_swing),
    .drv_pre     (drv_pre),
    .eq_code     (eq_code),
    .eq_en       (eq_en_w)
);

// File: tb/link_cfg_shadow_tb.sv
module link_cfg_shadow_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snoop_we = 1'b0;
    logic [19:0] snoop_addr = '0;
    logic [7:0]  snoop_wdata = '0;
    logic        lb_we = 1'b0;
    logic [3:0]  lb_addr = '0;
    logic [7:0]  lb_wdata = '0;
    logic [7:0]  lb_rdata;
    logic [1:0]  link_rate;
    logic [3:0]  lane_en;
    logic        cfg_err;
    logic [7:0]  drv_swing;
    logic [7:0]  drv_pre;
    logic [11:0] eq_code;

    link_cfg_shadow u_dut (
        .clk(clk), .rst_n(rst_n),
        .snoop_we(snoop_we), .snoop_addr(snoop_addr), .snoop_wdata(snoop_wdata),
        .lb_we(lb_we), .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata),
        .link_rate(link_rate), .lane_en(lane_en), .cfg_err(cfg_err),
        .drv_swing(drv_swing), .drv_pre(drv_pre), .eq_code(eq_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // Reference model state
    int m_bw, m_mask, m_lcbad, m_hi, m_mid, m_lo, m_eqen, m_tren;
    int m_sw[4], m_pe[4], m_pc[4];
    int m_eq[4][4];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void m_reset();
        m_bw = 1; m_mask = 0; m_lcbad = 0; m_hi = 0; m_mid = 0; m_lo = 0;
        m_eqen = 0; m_tren = 1;
        for (int l = 0; l < 4; l++) begin
            m_sw[l] = 0; m_pe[l] = 0; m_pc[l] = 0;
            for (int k = 0; k < 4; k++) m_eq[l][k] = 0;
        end
    endfunction

    function automatic void m_swrite(input int a, input int d);
        if (a == 'h100) m_bw = (d == 'h06) ? 0 : (d == 'h0A) ? 1 : 2;
        else if (a == 'h101) begin
            m_lcbad = 0;
            if (d == 0) m_mask = 0;
            else if (d == 1) m_mask = 1;
            else if (d == 2) m_mask = 3;
            else if (d == 4) m_mask = 15;
            else begin m_mask = 0; m_lcbad = 1; end
        end
        else if (a >= 'h103 && a <= 'h106) begin
            m_sw[a - 'h103] = d & 3;
            m_pe[a - 'h103] = (d >> 3) & 3;
        end
        else if (a == 'h10F || a == 'h110) begin
            m_pc[2*(a - 'h10F)]     = d & 3;
            m_pc[2*(a - 'h10F) + 1] = (d >> 4) & 3;
        end
    endfunction

    function automatic int m_sread(input int a);
        if (a == 'h100) return m_bw;
        if (a == 'h101) return m_mask;
        if (a >= 'h103 && a <= 'h106) return (m_pe[a-'h103] << 2) | m_sw[a-'h103];
        if (a == 'h10F || a == 'h110)
            return (m_pc[2*(a-'h10F)+1] << 2) | m_pc[2*(a-'h10F)];
        return 0;
    endfunction

    function automatic int m_iaddr();
        return (m_hi << 16) | (m_mid << 8) | m_lo;
    endfunction

    function automatic int m_lread(input int a);
        if (a == 0) return m_hi;
        if (a == 1) return m_mid;
        if (a == 2) return m_lo;
        if (a == 3) return m_sread(m_iaddr());
        if (a == 4) return (m_eqen << 7) | (m_tren << 6);
        if (a >= 8) begin
            if ((a % 2) == 0) return (m_eq[(a-8)/2][0] << 4) | m_eq[(a-8)/2][1];
            return (m_eq[(a-8)/2][2] << 4) | m_eq[(a-8)/2][3];
        end
        return 0;
    endfunction

    function automatic int m_err();
        int e = m_lcbad;
        for (int l = 0; l < 4; l++) if (m_sw[l] + m_pe[l] > 3) e = 1;
        return e;
    endfunction

    // One clock: drive inputs, advance the model, compare after the edge
    task automatic cyc(input bit swe, input int sa, input int sd,
                       input bit lwe, input int la, input int ld, input string tag);
        int ia;
        snoop_we = swe; snoop_addr = sa[19:0]; snoop_wdata = sd[7:0];
        lb_we = lwe; lb_addr = la[3:0]; lb_wdata = ld[7:0];
        ia = m_iaddr();
        if (lwe) begin
            if (la == 4 && ((ld >> 5) & 1)) for (int l = 0; l < 4; l++) begin
                m_sw[l] = 0; m_pe[l] = 0;
            end
            if (la == 3 && !(swe && sa == ia)) m_swrite(ia, ld & 255);
        end
        if (swe) m_swrite(sa, sd & 255);
        if (lwe) begin
            if (la == 0) m_hi = ld & 15;
            else if (la == 1) m_mid = ld & 255;
            else if (la == 2) m_lo = ld & 255;
            else if (la == 4) begin m_eqen = (ld >> 7) & 1; m_tren = (ld >> 6) & 1; end
            else if (la >= 8) begin
                if ((la % 2) == 0) begin
                    m_eq[(la-8)/2][0] = (ld >> 4) & 7; m_eq[(la-8)/2][1] = ld & 7;
                end else begin
                    m_eq[(la-8)/2][2] = (ld >> 4) & 7; m_eq[(la-8)/2][3] = ld & 7;
                end
            end
        end
        @(posedge clk);
        #1;
        begin
            int esw = 0, epe = 0, eeq = 0;
            for (int l = 0; l < 4; l++) begin
                esw |= m_sw[l] << (2*l);
                epe |= m_pe[l] << (2*l);
                eeq |= (m_eqen == 0 ? 0 : (m_tren != 0 ? m_eq[l][m_pe[l]] : m_eq[l][1])) << (3*l);
            end
            chk("R1 link_rate", int'(link_rate), m_bw);
            chk("R2 lane_en", int'(lane_en), m_err() != 0 ? 0 : m_mask);
            chk("R12 cfg_err", int'(cfg_err), m_err());
            chk("R3 drv_swing", int'(drv_swing), esw);
            chk("R3 drv_pre", int'(drv_pre), epe);
            chk("R8 eq_code", int'(eq_code), eeq);
            chk(tag, int'(lb_rdata), m_lread(la));
        end
        @(negedge clk);
    endtask

    task automatic set_ia(input int a);
        cyc(0, 0, 0, 1, 0, (a >> 16) & 15, "R6 addr hi");
        cyc(0, 0, 0, 1, 1, (a >> 8) & 255, "R6 addr mid");
        cyc(0, 0, 0, 1, 2, a & 255, "R6 addr lo");
    endtask

    task automatic iread(input int a, input int exp, input string tag);
        set_ia(a);
        cyc(0, 0, 0, 0, 3, 0, tag);
        chk(tag, int'(lb_rdata), exp);
    endtask

    task automatic iwrite(input int a, input int d, input string tag);
        set_ia(a);
        cyc(0, 0, 0, 1, 3, d, tag);
    endtask

    task automatic swr(input int a, input int d, input string tag);
        cyc(1, a, d, 0, 3, 0, tag);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL all watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset values
        cyc(0, 0, 0, 0, 4, 0, "R11 ctrl");
        chk("R11 ctrl reads 40h", int'(lb_rdata), 'h40);
        chk("R11 link_rate", int'(link_rate), 1);
        chk("R11 lane_en", int'(lane_en), 0);
        chk("R11 eq_code", int'(eq_code), 0);
        iread('h100, 'h01, "R11 bandwidth reads 01h");
        iread('h104, 'h00, "R11 training reads 00h");

        // R1 bandwidth encodings
        swr('h100, 'h06, "R1 bw 06"); iread('h100, 0, "R1 bw 06 reads 00h");
        swr('h100, 'h0A, "R1 bw 0A"); iread('h100, 1, "R1 bw 0A reads 01h");
        swr('h100, 'h14, "R1 bw 14"); iread('h100, 2, "R1 bw 14 reads 02h");
        swr('h100, 'h06, "R1 bw 06");
        swr('h100, 'h33, "R1 bw other"); iread('h100, 2, "R1 bw other reads 02h");

        // R2 lane counts
        swr('h101, 'h01, "R2 lc 1"); chk("R2 one lane", int'(lane_en), 1);
        swr('h101, 'h02, "R2 lc 2"); chk("R2 two lanes", int'(lane_en), 3);
        swr('h101, 'h04, "R2 lc 4"); chk("R2 four lanes", int'(lane_en), 15);
        iread('h101, 'h0F, "R2 four lanes reads 0Fh");
        swr('h101, 'h03, "R2 lc bad"); chk("R2 bad count lanes off", int'(lane_en), 0);
        chk("R12 bad count flags", int'(cfg_err), 1);
        iread('h101, 0, "R2 bad count reads 00h");
        swr('h101, 'h04, "R2 lc 4 again"); chk("R2 restored", int'(lane_en), 15);

        // R3 training layout through the data window
        iwrite('h103, 'hED, "R3 train write");
        cyc(0, 0, 0, 0, 3, 0, "R3 train read");
        chk("R3 train reads 05h", int'(lb_rdata), 'h05);
        chk("R3 lane0 swing", int'(drv_swing[1:0]), 1);

        // R4 forbidden pair then recovery
        swr('h104, 'h1B, "R4 bad pair");
        chk("R4 bad pair gates lanes", int'(lane_en), 0);
        chk("R12 bad pair flags", int'(cfg_err), 1);
        swr('h105, 'h10, "R4 other lane 0/10");
        chk("R4 still gated", int'(lane_en), 0);
        swr('h104, 'h0A, "R4 valid 10/01");
        chk("R4 lanes back", int'(lane_en), 15);

        // R5 post-cursor layout
        iwrite('h10F, 'h31, "R5 pc 01");
        cyc(0, 0, 0, 0, 3, 0, "R5 pc 01 read");
        chk("R5 lanes 0/1 read 0Dh", int'(lb_rdata), 'h0D);
        swr('h110, 'h12, "R5 pc 23");
        iread('h110, 'h06, "R5 lanes 2/3 read 06h");

        // R6 unmapped target and address byte width
        iwrite('h12345, 'hFF, "R6 unmapped write");
        cyc(0, 0, 0, 0, 3, 0, "R6 unmapped read");
        chk("R6 unmapped reads 00h", int'(lb_rdata), 0);
        cyc(0, 0, 0, 1, 0, 'hFF, "R6 hi write");
        chk("R6 hi keeps 4 bits", int'(lb_rdata), 'h0F);
        cyc(0, 0, 0, 1, 6, 'hFF, "R6 reserved local");
        chk("R6 reserved local reads 00h", int'(lb_rdata), 0);

        // R9 table layout, R8 selection
        for (int l = 0; l < 4; l++) begin
            cyc(0, 0, 0, 1, 8 + 2*l, 'hFF - l, "R9 table A");
            cyc(0, 0, 0, 1, 9 + 2*l, ((l + 2) << 4) | (l + 3), "R9 table B");
        end
        cyc(0, 0, 0, 0, 8, 0, "R9 lane0 A");
        chk("R9 reserved bits read 0", int'(lb_rdata), 'h77);
        swr('h103, 'h00, "R8 lane0 pre0");
        swr('h104, 'h08, "R8 lane1 pre1");
        swr('h105, 'h10, "R8 lane2 pre2");
        swr('h106, 'h18, "R8 lane3 pre3");
        chk("R8 disabled code 0", int'(eq_code), 0);
        cyc(0, 0, 0, 1, 4, 'hC0, "R8 enable trained");
        chk("R8 lane3 level3 field", int'(eq_code[11:9]), 6);
        chk("R8 lane0 level0 field", int'(eq_code[2:0]), 7);
        cyc(0, 0, 0, 1, 4, 'h80, "R8 training off");
        chk("R8 lane2 level1 field", int'(eq_code[8:6]), 5);

        // R7 clear, and snoop winning over clear
        cyc(0, 0, 0, 1, 4, 'hE0, "R7 clear");
        chk("R7 clear zeroes drive", int'(drv_pre), 0);
        chk("R7 clear bit reads 0", int'(lb_rdata), 'hC0);
        swr('h105, 'h09, "R7 setup");
        cyc(1, 'h105, 'h0A, 1, 4, 'hE0, "R7 snoop over clear");
        chk("R7 snooped lane2 kept", int'(drv_swing[5:4]), 2);

        // R10 collisions
        set_ia('h100);
        cyc(1, 'h100, 'h06, 1, 3, 'h14, "R10 same address");
        chk("R10 snoop wins", int'(link_rate), 0);
        cyc(1, 'h101, 'h02, 1, 3, 'h0A, "R10 different address");
        chk("R10 both rate", int'(link_rate), 1);
        chk("R10 both lanes", int'(lane_en), 3);

        // Random mix compared every cycle
        for (int n = 0; n < 3000; n++) begin
            int sel = $urandom_range(0, 8);
            int sa = (sel == 0) ? 'h100 : (sel == 1) ? 'h101 : (sel < 6) ? 'h101 + sel :
                     (sel == 6) ? 'h10F : (sel == 7) ? 'h110 : 'h12345;
            int la = $urandom_range(0, 15);
            int ld = $urandom_range(0, 255);
            if (la == 0) ld = 0;
            if (la == 1) ld = 1;
            if (la == 2) ld = $urandom_range(0, 1) ? 'h00 + $urandom_range(0, 6) : 'h0F;
            cyc($urandom_range(0, 1), sa, $urandom_range(0, 255),
                $urandom_range(0, 1), la, ld, "R10 random read");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule